// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave

This block is a two-wire serial slave that gives a host access to a bank of fifteen 8-bit configuration registers. Every access is a block transfer. To write, the host names a starting index, then says how many bytes follow, then sends those bytes. They land at consecutive register positions. To read, the host first sets the index in a short write phase and then issues a repeated START with the read address. The slave answers with a count byte, which it takes from a writable register, and then streams register contents from the chosen index onward until the host declines a byte.

Both bus lines are sampled by the system clock through a two-stage synchronizer. The slave never pulls the clock low, so it does not stretch the clock. Its data output is an open-drain drive-low enable. The whole register bank is also presented in parallel on a flat output bus, so that neighbouring logic can use the settings directly.

Top module: `i2cIndexedRegs`

## Requirements
- R1: The slave acknowledges only the address bytes D2h (write) and D3h (read). Any other address byte is not acknowledged, and the slave then keeps SDA released until the next START or STOP.
- R2: A write transfer carries an index byte N, a count byte X and then X data bytes. The slave acknowledges every one of these bytes and stores the data bytes at N, N+1, ... in order.
- R3: Data bytes sent after the announced count is used up are not acknowledged, and they change no register.
- R4: After a repeated START with D3h, the first byte the slave returns is the current value of register 6. The bytes after it are register contents starting at the previously set index and rising by one per byte. Each byte is sent MSB first.
- R5: When the host does not acknowledge a byte the slave has sent, the slave releases SDA and drives nothing further until a START or STOP.
- R6: The register index advances by one after each byte written or sent and wraps from 14 to 0. An index byte of 15 or more selects register 0.
- R7: After reset, register 6 reads 06h, register 8 reads CCh, register 7 reads the identity byte, and every other writable bit reads 0.
- R8: Register 7 is entirely read-only: its bits 7:4 are a revision code and bits 3:0 a vendor code, both parameters. Register 10 bit 5 reads the live value of the status input. Register 14 bit 7 always reads 0. Writes leave these bits unchanged and still update the other bits of the same byte.
- R9: Register 8 holds two 4-bit fields, in bits 7:4 and 3:0. Each field accepts only the codes 0000, 0100, 1000, 1100, 1101, 1110 and 1111. A write that carries an invalid code leaves that field unchanged, while a valid code in the other field is still taken.
- R10: A START seen part-way through a byte discards the partial byte and begins a new address phase. A STOP at any point returns the slave to idle. Bytes already acknowledged stay written.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: Output regFlat shows the readable value of register i on bits 8i+7 down to 8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaDriveLow | output | 1 | High to pull SDA low (open-drain enable) |
| statusIn | input | 1 | Live status bit shown in register 10 bit 5 |
| regFlat | output | 120 | All registers in parallel, register i at bits 8i+7:8i |

## Verification
The index pointer can wrap in the same cycle that a data byte is committed to register 14. On the read side, the pointer also advances in the cycle that a byte is handed to the shifter. Both cases are provoked with transfers that start at index 13 or 14 and run past the end of the bank. They are judged by register 0 and register 1 receiving the bytes that follow, by register 14 keeping its fixed-zero top bit, and by a read from index 14 returning register 14 and then register 0. The same wrap is also watched continuously by a property on the pointer after every step.

// File: rtl/i2cBlkPkg.sv
package i2cBlkPkg;

  // Register positions whose behaviour is special
  localparam int CNT_IDX  = 6;
  localparam int ID_IDX   = 7;
  localparam int SKEW_IDX = 8;
  localparam int STAT_IDX = 10;
  localparam int STAT_BIT = 5;
  localparam int RSV_IDX  = 14;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    B_ADDR, B_INDEX, B_COUNT, B_DATA
  } byteRole_t;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       loadIdx;
    logic       wrByte;
    logic       advRd;
    logic [7:0] data;
  } ctrlStrb_t;

  function automatic logic [7:0] roMask(input int i);
    case (i)
      ID_IDX:   return 8'hFF;
      STAT_IDX: return 8'h01 << STAT_BIT;
      RSV_IDX:  return 8'h80;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rstVal(input int i);
    case (i)
      CNT_IDX:  return 8'h06;
      SKEW_IDX: return 8'hCC;
      default:  return 8'h00;
    endcase
  endfunction

  // valid skew codes: low two bits clear, or both upper bits set
  function automatic logic skewOk(input logic [3:0] c);
    return (c[1:0] == 2'b00) || (c[3:2] == 2'b11);
  endfunction

endpackage

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cBlkPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [7:0] cntByte,
  input  logic [7:0] rdByte,
  output ctrlStrb_t strb,
  output logic      sdaDriveLow
);

  logic [2:0] sclSh, sdaSh;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t  state;
  byteRole_t  role;
  logic [2:0] bitCnt;
  logic [7:0] shReg;
  logic [7:0] left;
  logic       rxDone, readDir, hostAck, drvLow;
  logic       addrHit, accept, decide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= 3'b111;
      sdaSh <= 3'b111;
    end else begin
      sclSh <= {sclSh[1:0], sclIn};
      sdaSh <= {sdaSh[1:0], sdaIn};
    end
  end

  assign sclNow   = sclSh[1];
  assign sclOld   = sclSh[2];
  assign sdaNow   = sdaSh[1];
  assign sdaOld   = sdaSh[2];
  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;

  assign addrHit = (shReg[7:1] == DEV_ADDR);

  always_comb begin
    case (role)
      B_ADDR:  accept = addrHit;
      B_DATA:  accept = (left != 8'd0);
      default: accept = 1'b1;
    endcase
  end

  assign decide = (state == S_RX) && rxDone && sclFall;

  always_comb begin
    strb.loadIdx = decide && (role == B_INDEX);
    strb.wrByte  = decide && (role == B_DATA) && (left != 8'd0);
    strb.advRd   = (state == S_TXACK) && sclFall && hostAck;
    strb.data    = shReg;
  end

  function automatic byteRole_t nextRole(input byteRole_t r);
    case (r)
      B_ADDR:  return B_INDEX;
      B_INDEX: return B_COUNT;
      default: return B_DATA;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      role    <= B_ADDR;
      bitCnt  <= 3'd0;
      shReg   <= 8'd0;
      left    <= 8'd0;
      rxDone  <= 1'b0;
      readDir <= 1'b0;
      hostAck <= 1'b0;
      drvLow  <= 1'b0;
    end else if (startDet) begin
      state  <= S_RX;
      role   <= B_ADDR;
      bitCnt <= 3'd0;
      rxDone <= 1'b0;
      drvLow <= 1'b0;
    end else if (stopDet) begin
      state  <= S_IDLE;
      rxDone <= 1'b0;
      drvLow <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (sclRise && !rxDone) begin
            shReg  <= {shReg[6:0], sdaNow};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) rxDone <= 1'b1;
          end else if (decide) begin
            rxDone <= 1'b0;
            if (accept) begin
              drvLow <= 1'b1;
              state  <= S_RXACK;
              case (role)
                B_ADDR:  readDir <= shReg[0];
                B_COUNT: left    <= shReg;
                B_DATA:  left    <= left - 8'd1;
                default: ;
              endcase
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_RXACK: begin
          if (sclFall) begin
            bitCnt <= 3'd0;
            if (role == B_ADDR && readDir) begin
              state  <= S_TX;
              shReg  <= cntByte;
              drvLow <= ~cntByte[7];
            end else begin
              state  <= S_RX;
              role   <= nextRole(role);
              drvLow <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              drvLow <= 1'b0;
              state  <= S_TXACK;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              drvLow <= ~shReg[6];
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            hostAck <= ~sdaNow;
          end else if (sclFall) begin
            if (hostAck) begin
              shReg  <= rdByte;
              drvLow <= ~rdByte[7];
              bitCnt <= 3'd0;
              state  <= S_TX;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDriveLow = drvLow;

endmodule

// File: rtl/regBankPath.sv
module regBankPath
  import i2cBlkPkg::*;
#(
  parameter int         NUM_REGS = 15,
  parameter logic [3:0] REV_ID   = 4'h1,
  parameter logic [3:0] VEN_ID   = 4'h1,
  localparam int        IDX_W    = $clog2(NUM_REGS),
  localparam int        FLAT_W   = NUM_REGS * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              statusIn,
  output logic [7:0]        rdByte,
  output logic [7:0]        cntByte,
  output logic [IDX_W-1:0]  idxNow,
  output logic [FLAT_W-1:0] regFlat
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0]  idx;
  logic [FLAT_W-1:0] viewFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strb.loadIdx) begin
      idx <= (strb.data < 8'(NUM_REGS)) ? strb.data[IDX_W-1:0] : '0;
    end else if (strb.wrByte || strb.advRd) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [7:0] RO = roMask(g);
    logic [7:0] held, nxt, overlay;

    if (g == SKEW_IDX) begin : gSkew
      always_comb begin
        nxt = held;
        if (skewOk(strb.data[7:4])) nxt[7:4] = strb.data[7:4];
        if (skewOk(strb.data[3:0])) nxt[3:0] = strb.data[3:0];
      end
    end else begin : gPlain
      assign nxt = strb.data & ~RO;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) held <= rstVal(g) & ~RO;
      else if (strb.wrByte && idx == IDX_W'(g)) held <= nxt;
    end

    if (g == ID_IDX) begin : gId
      assign overlay = {REV_ID, VEN_ID};
    end else if (g == STAT_IDX) begin : gStat
      assign overlay = statusIn ? (8'h01 << STAT_BIT) : 8'h00;
    end else begin : gNone
      assign overlay = 8'h00;
    end

    assign viewFlat[g*8 +: 8] = held | overlay;
  end

  assign rdByte  = viewFlat[{idx, 3'b000} +: 8];
  assign cntByte = viewFlat[CNT_IDX*8 +: 8];
  assign idxNow  = idx;
  assign regFlat = viewFlat;

endmodule

// File: rtl/i2cIndexedRegs.sv
module i2cIndexedRegs
  import i2cBlkPkg::*;
#(
  parameter int         NUM_REGS = 15,
  parameter logic [3:0] REV_ID   = 4'h1,
  parameter logic [3:0] VEN_ID   = 4'h1,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  input  logic                  statusIn,
  output logic [NUM_REGS*8-1:0] regFlat
);

  ctrlStrb_t        strb;
  logic [7:0]       rdByte, cntByte;
  logic [IDX_W-1:0] idxNow;
  logic             idxStep;

  i2cSlaveCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cntByte(cntByte), .rdByte(rdByte), .strb(strb),
    .sdaDriveLow(sdaDriveLow)
  );

  regBankPath #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID), .VEN_ID(VEN_ID)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .statusIn(statusIn),
    .rdByte(rdByte), .cntByte(cntByte), .idxNow(idxNow), .regFlat(regFlat)
  );

  assign idxStep = strb.wrByte | strb.advRd;

endmodule

// File: rtl/i2cIndexedRegsChk.sv
module i2cIndexedRegsChk
  import i2cBlkPkg::*;
#(
  parameter int         NUM_REGS = 15,
  parameter logic [3:0] REV_ID   = 4'h1,
  parameter logic [3:0] VEN_ID   = 4'h1,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] regFlat,
  input logic [IDX_W-1:0]      idxNow,
  input logic                  idxStep
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  // R11: drive changes only with SCL low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  // R6: pointer stays inside the bank
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    idxNow <= LAST);

  // R6: each step moves the pointer by one with wrap
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    idxStep |=> idxNow == (($past(idxNow) == LAST) ? '0 : $past(idxNow) + 1'b1));

  // R9: both skew fields always hold an accepted code
  p_skew_codes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regFlat[SKEW_IDX*8+4 +: 4] inside {4'h0, 4'h4, 4'h8, 4'hC, 4'hD, 4'hE, 4'hF}) &&
    (regFlat[SKEW_IDX*8 +: 4]   inside {4'h0, 4'h4, 4'h8, 4'hC, 4'hD, 4'hE, 4'hF}));

  // R8: read-only identity byte and fixed-zero bit never move
  p_ro_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regFlat[ID_IDX*8 +: 8]) && !regFlat[RSV_IDX*8+7]);

endmodule

bind i2cIndexedRegs i2cIndexedRegsChk #(
  .NUM_REGS(NUM_REGS), .REV_ID(REV_ID), .VEN_ID(VEN_ID)
) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .regFlat(regFlat), .idxNow(idxNow), .idxStep(idxStep)
);

// File: tb/tb_i2cIndexedRegs.sv
module tb_i2cIndexedRegs;

  localparam int NREG = 15;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaHost = 1'b1;
  logic statusIn = 1'b0;
  logic sdaBus;
  logic sdaDriveLow;
  logic [NREG*8-1:0] regFlat;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  logic [7:0] mdl [NREG];

  always #4 clk = ~clk;

  assign sdaBus = sdaHost & ~sdaDriveLow;

  i2cIndexedRegs dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .statusIn(statusIn), .regFlat(regFlat)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic codeOk(input logic [3:0] c);
    return c == 4'd0 || c == 4'd4 || c == 4'd8 || c >= 4'd12;
  endfunction

  function automatic void mdlWr(input int i, input logic [7:0] v);
    case (i)
      7: ;
      8: begin
        if (codeOk(v[7:4])) mdl[8][7:4] = v[7:4];
        if (codeOk(v[3:0])) mdl[8][3:0] = v[3:0];
      end
      10: mdl[10] = v & 8'hDF;
      14: mdl[14] = v & 8'h7F;
      default: mdl[i] = v;
    endcase
  endfunction

  function automatic logic [7:0] viewOf(input int i);
    if (i == 7) return 8'h11;
    if (i == 10) return mdl[10] | (statusIn ? 8'h20 : 8'h00);
    return mdl[i];
  endfunction

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startC;
    sdaHost = 1'b1; sclDrv = 1'b1; waitQ(1);
    sdaHost = 1'b0; waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic repStart;
    sdaHost = 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    sdaHost = 1'b0; waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic stopC;
    sdaHost = 1'b0; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    sdaHost = 1'b1; waitQ(1);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      sdaHost = b[k]; waitQ(1);
      sclDrv = 1'b1; waitQ(2);
      sclDrv = 1'b0; waitQ(1);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    sendBits(b, 8);
    sdaHost = 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    ackd = ~sdaBus; waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaHost = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      waitQ(1); sclDrv = 1'b1;
      waitQ(1); b[k] = sdaBus;
      waitQ(1); sclDrv = 1'b0;
      waitQ(1);
    end
    sdaHost = ~ackIt; waitQ(1);
    sclDrv = 1'b1; waitQ(2);
    sclDrv = 1'b0; waitQ(1);
    sdaHost = 1'b1;
  endtask

  task automatic chkView(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, regFlat[i*8 +: 8], viewOf(i));
  endtask

  // R2/R3/R6: block write, expected acks from the announced count
  task automatic wrSeq(input int idx, input int cnt, input int nSend,
                       input logic [7:0] d [8], input string tag);
    logic a;
    int pos;
    pos = (idx < NREG) ? idx : 0;
    startC;
    sendByte(8'hD2, a);        chk({tag, " R1 write address ack"}, 8'(a), 8'd1);
    sendByte(8'(idx), a);      chk({tag, " R2 index ack"}, 8'(a), 8'd1);
    sendByte(8'(cnt), a);      chk({tag, " R2 count ack"}, 8'(a), 8'd1);
    for (int k = 0; k < nSend; k++) begin
      sendByte(d[k], a);
      chk({tag, (k < cnt) ? " R2 data ack" : " R3 excess nack"}, 8'(a), 8'(k < cnt));
      if (k < cnt) begin
        mdlWr(pos, d[k]);
        pos = (pos + 1) % NREG;
      end
    end
    stopC;
    waitQ(1);
  endtask

  // R4/R5/R6: indexed read
  task automatic rdSeq(input int idx, input int nData, input string tag);
    logic a;
    logic [7:0] b;
    int pos;
    pos = (idx < NREG) ? idx : 0;
    startC;
    sendByte(8'hD2, a);
    sendByte(8'(idx), a);
    repStart;
    sendByte(8'hD3, a);        chk({tag, " R1 read address ack"}, 8'(a), 8'd1);
    recvByte(1'b1, b);         chk({tag, " R4 count byte"}, b, viewOf(6));
    for (int k = 0; k < nData; k++) begin
      recvByte(k < nData - 1, b);
      chk({tag, " R4 R6 read data"}, b, viewOf(pos));
      pos = (pos + 1) % NREG;
    end
    recvByte(1'b0, b);         chk({tag, " R5 released after nack"}, b, 8'hFF);
    stopC;
    waitQ(1);
  endtask

  initial begin
    logic a;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl[6] = 8'h06;
    mdl[8] = 8'hCC;

    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 idle release", 8'(sdaDriveLow), 8'd0);
    chkView("R7 R12 reset view");

    wrSeq(0, 5, 5, '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 0, 0, 0}, "blk0");
    chkView("R2 R12 after block write");
    rdSeq(1, 3, "rd1");

    wrSeq(6, 1, 1, '{8'h03, 0, 0, 0, 0, 0, 0, 0}, "cnt");
    rdSeq(0, 2, "rdcnt");

    // wrap during write, including fixed-zero bit of register 14
    wrSeq(13, 4, 4, '{8'h5C, 8'hFF, 8'h3E, 8'h71, 0, 0, 0, 0}, "wrap");
    chkView("R6 R8 wrap write");
    rdSeq(14, 3, "rdwrap");

    wrSeq(200, 1, 1, '{8'h5A, 0, 0, 0, 0, 0, 0, 0}, "bigidx");
    chkView("R6 large index selects 0");

    wrSeq(2, 1, 2, '{8'h66, 8'h99, 0, 0, 0, 0, 0, 0}, "excess");
    chkView("R3 excess byte not stored");

    wrSeq(3, 0, 1, '{8'h44, 0, 0, 0, 0, 0, 0, 0}, "zero");
    chkView("R3 zero count stores nothing");

    // read-only bits
    wrSeq(7, 1, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "id");
    chkView("R8 identity byte unchanged");
    wrSeq(10, 1, 1, '{8'hFF, 0, 0, 0, 0, 0, 0, 0}, "stat");
    chk("R8 status bit low", regFlat[10*8 +: 8], 8'hDF);
    statusIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 status bit follows input", regFlat[10*8 +: 8], 8'hFF);
    wrSeq(10, 1, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "stat0");
    chk("R8 status bit survives write", regFlat[10*8 +: 8], 8'h20);
    rdSeq(9, 2, "rdstat");

    // skew field sweep
    for (int c = 0; c < 16; c++) begin
      logic [3:0] hi;
      hi = 4'(c);
      wrSeq(8, 1, 1, '{{hi, hi ^ 4'h4}, 0, 0, 0, 0, 0, 0, 0}, "skew");
      chk("R9 skew fields", regFlat[8*8 +: 8], mdl[8]);
    end
    rdSeq(8, 1, "rdskew");

    // address sweep
    for (int ad = 0; ad < 128; ad++) begin
      startC;
      sendByte({ad[6:0], 1'b0}, a);
      chk("R1 address match", 8'(a), 8'(ad == 'h69));
      stopC;
    end
    startC;
    sendByte(8'hA0, a);
    sendByte(8'h00, a);
    chk("R1 off bus after foreign address", 8'(a), 8'd0);
    stopC;

    // START and STOP part-way through a byte
    startC;
    sendByte(8'hD2, a);
    sendByte(8'h04, a);
    sendByte(8'h02, a);
    sendBits(8'hEE, 4);
    repStart;
    sendByte(8'hD2, a);        chk("R10 address after mid-byte start", 8'(a), 8'd1);
    sendByte(8'h09, a);
    sendByte(8'h01, a);
    sendByte(8'h77, a);
    mdlWr(9, 8'h77);
    stopC;
    chkView("R10 partial byte dropped");

    startC;
    sendByte(8'hD2, a);
    sendByte(8'h03, a);
    sendByte(8'h02, a);
    sendByte(8'h12, a);
    mdlWr(3, 8'h12);
    sendBits(8'h34, 5);
    stopC;
    waitQ(1);
    chkView("R10 stop mid-byte keeps acked bytes");
    chk("R10 released after stop", 8'(sdaDriveLow), 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule